// File: doc/BRIEF.md
# Bus Master Lane Steering Unit

This unit sits between a requesting agent and a 32-bit big-endian system bus, on the master side. For writes it places a 1, 2 or 4 byte operand on the correct byte lanes of the write data bus. It copies the operand onto more lanes in a fixed partial pattern, so that a port-sizing stage further down can serve byte-wide and halfword-wide slaves without moving data itself. For reads it picks the addressed lanes out of the returned bus word and hands back a right-justified, zero-extended operand.

A request for a 16-byte line becomes one address phase followed by four longword data beats. Each beat advances only when the slave signals ready. The bus address steps by four for every beat. Line write data is taken from a 128-bit operand, and line read data is gathered into a 128-bit result. A size and offset pair that the bus cannot carry raises a one-cycle error flag and starts no bus cycle. Requests are accepted only while no transfer is in progress.

Top module: `bus_lane_steer`

## Requirements
- R1: After synchronous reset, `bus_valid`, `done`, `err` and `rd_data` are all zero.
- R2: A legal request sampled while idle makes `bus_valid` high on the following cycle. In that cycle `bus_addr` equals the request address, `bus_size` the size code and `bus_write` the direction. Size codes are 2'b01 byte, 2'b10 word, 2'b00 longword and 2'b11 line.
- R3: Legal pairs are: byte at any offset; word at offset 0 or 2; longword at offset 0; line with address bits [3:0] all zero. Any other request pulses `err` for exactly one cycle, leaves `bus_valid` low and leaves `rd_data` unchanged.
- R4: On a byte write, operand bits [7:0] appear on lane [31:24]. They also appear on lane [23:16], [15:8] or [7:0] when the offset is 1, 2 or 3 respectively. Every other lane is zero.
- R5: On a word write, operand bits [15:0] appear on [31:16]. At offset 2 they are also copied onto [15:0]; at offset 0, [15:0] is zero.
- R6: On a longword write, `bus_wdata` equals operand bits [31:0], most significant byte on [31:24].
- R7: On a byte read, `rd_data` becomes the lane at offset 0, 1, 2 or 3 ([31:24], [23:16], [15:8], [7:0]), zero-extended.
- R8: On a word read, `rd_data` becomes [31:16] for offset 0 and [15:0] for offset 2, zero-extended.
- R9: On a longword read, `rd_data` becomes the full 32-bit bus word, zero-extended.
- R10: A line transfer takes four beats. Beat k is at address base+4k and, for a write, drives operand bits [127-32k:96-32k]. For a read, beat k's bus word lands in `rd_data` bits [127-32k:96-32k].
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_size`, `bus_write` and `bus_wdata` hold their values.
- R12: `done` pulses for one cycle, in the cycle after the final beat's `bus_ready`. In that same cycle `bus_valid` is low and `rd_data` holds the read result. Write transfers leave `rd_data` unchanged.
- R13: A request presented while a transfer is in progress is ignored and does not alter the bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32*LINE_BEATS | Right-justified write operand |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W | Bus address of the current beat |
| bus_size | output | 2 | Size code on the bus |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ready | input | 1 | Slave accepts the current beat |
| bus_rdata | input | 32 | Read data of the current beat |
| rd_data | output | 32*LINE_BEATS | Right-justified, zero-extended read result |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal request pulse |

## Verification
The bench builds the unit with its default parameters: a 32-bit address and four beats per line. That makes the line exactly 16 bytes, so the beat-index rollover, the 16-byte alignment rule and the 128-bit gather and scatter are all reachable. Random slave stalls of zero to two cycles hit both back-to-back beats and held beats. Requests injected during stalls probe the busy-ignore rule. Every legal and many illegal size and offset pairs occur under the fixed seed.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W = 8;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / LANE_W;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;
endpackage

// File: rtl/bls_wr_steer.sv
module bls_wr_steer
  import bls_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       off,
  input  logic [BUS_W-1:0] op,
  output logic [BUS_W-1:0] lanes
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = BUS_W - 1 - k * LANE_W;
    // byte index inside a halfword for this lane: 0 = upper, 1 = lower
    localparam int HW_IDX = k % 2;
    logic [LANE_W-1:0] lane_v;

    always_comb begin
      lane_v = '0;
      unique case (size)
        SZ_BYTE: begin
          if (k == 0 || off == 2'(k)) lane_v = op[LANE_W-1:0];
        end
        SZ_WORD: begin
          if (k < 2 || off == 2'd2)
            lane_v = op[2*LANE_W-1-HW_IDX*LANE_W -: LANE_W];
        end
        default: lane_v = op[HI -: LANE_W];
      endcase
    end

    assign lanes[HI -: LANE_W] = lane_v;
  end
endmodule

// File: rtl/bls_rd_extract.sv
module bls_rd_extract
  import bls_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       off,
  input  logic [BUS_W-1:0] rdata,
  output logic [BUS_W-1:0] operand
);
  logic [LANE_W-1:0] byte_sel;
  logic [LANES-1:0][LANE_W-1:0] lane_arr;

  for (genvar k = 0; k < LANES; k++) begin : g_split
    // lane_arr[0] is the least significant lane
    assign lane_arr[k] = rdata[k*LANE_W +: LANE_W];
  end

  assign byte_sel = lane_arr[2'(LANES - 1) - off];

  always_comb begin
    operand = '0;
    unique case (size)
      SZ_BYTE: operand[LANE_W-1:0]   = byte_sel;
      SZ_WORD: operand[2*LANE_W-1:0] = off[1] ? rdata[2*LANE_W-1:0]
                                              : rdata[BUS_W-1 -: 2*LANE_W];
      default: operand = rdata;
    endcase
  end
endmodule

// File: rtl/bls_line_seq.sv
module bls_line_seq
  import bls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BEATS = 4,
  localparam int LINE_W     = LINE_BEATS * BUS_W,
  localparam int LINE_OFF_W = $clog2(LINE_BEATS * (BUS_W / LANE_W)),
  localparam int BEAT_W     = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic [BUS_W-1:0]  steered_wdata,
  input  logic [BUS_W-1:0]  short_rdata,
  input  logic              bus_ready,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic [LINE_W-1:0] rd_data,
  output logic              done,
  output logic              err
);
  logic              is_line;
  logic [BEAT_W-1:0] beat;
  logic [LINE_W-1:0] wbuf;
  logic [LINE_W-1:0] rbuf;
  logic              legal;
  logic              last_beat;
  logic [LINE_W-1:0] line_gather;

  always_comb begin
    unique case (req_size)
      SZ_BYTE: legal = 1'b1;
      SZ_WORD: legal = ~req_addr[0];
      SZ_LONG: legal = (req_addr[1:0] == 2'b00);
      default: legal = (req_addr[LINE_OFF_W-1:0] == '0);
    endcase
  end

  assign last_beat   = !is_line || (beat == BEAT_W'(LINE_BEATS - 1));
  assign line_gather = {rbuf[LINE_W-BUS_W-1:0], bus_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= SZ_LONG;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      is_line   <= 1'b0;
      beat      <= '0;
      wbuf      <= '0;
      rbuf      <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!bus_valid) begin
        if (req_valid) begin
          if (legal) begin
            bus_valid <= 1'b1;
            bus_addr  <= req_addr;
            bus_size  <= req_size;
            bus_write <= req_write;
            is_line   <= (req_size == SZ_LINE);
            beat      <= '0;
            rbuf      <= '0;
            if (req_size == SZ_LINE) begin
              bus_wdata <= req_wdata[LINE_W-1 -: BUS_W];
              wbuf      <= req_wdata << BUS_W;
            end else begin
              bus_wdata <= steered_wdata;
              wbuf      <= '0;
            end
          end else begin
            err <= 1'b1;
          end
        end
      end else if (bus_ready) begin
        if (last_beat) begin
          bus_valid <= 1'b0;
          done      <= 1'b1;
          if (!bus_write) rd_data <= is_line ? line_gather : LINE_W'(short_rdata);
        end else begin
          beat      <= beat + 1'b1;
          bus_addr  <= bus_addr + ADDR_W'(4);
          bus_wdata <= wbuf[LINE_W-1 -: BUS_W];
          wbuf      <= wbuf << BUS_W;
          rbuf      <= line_gather;
        end
      end
    end
  end

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !bus_valid && !done);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
      && $stable(bus_wdata) && $stable(bus_size) && $stable(bus_write));

  // R10
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready |=> done || (bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(4)));

  // R10
  line_only_steps_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready && bus_size != SZ_LINE |=> done);
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
  import bls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BEATS = 4,
  localparam int LINE_W    = LINE_BEATS * 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ready,
  input  logic [31:0]       bus_rdata,
  output logic [LINE_W-1:0] rd_data,
  output logic              done,
  output logic              err
);
  logic [BUS_W-1:0] steered_wdata;
  logic [BUS_W-1:0] short_rdata;

  bls_wr_steer u_wr (
    .size  (req_size),
    .off   (req_addr[1:0]),
    .op    (req_wdata[BUS_W-1:0]),
    .lanes (steered_wdata)
  );

  bls_rd_extract u_rd (
    .size    (bus_size),
    .off     (bus_addr[1:0]),
    .rdata   (bus_rdata),
    .operand (short_rdata)
  );

  bls_line_seq #(
    .ADDR_W     (ADDR_W),
    .LINE_BEATS (LINE_BEATS)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_write     (req_write),
    .req_wdata     (req_wdata),
    .steered_wdata (steered_wdata),
    .short_rdata   (short_rdata),
    .bus_ready     (bus_ready),
    .bus_rdata     (bus_rdata),
    .bus_valid     (bus_valid),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_write     (bus_write),
    .bus_wdata     (bus_wdata),
    .rd_data       (rd_data),
    .done          (done),
    .err           (err)
  );

  // R4
  byte_repl_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_size == SZ_BYTE |->
      bus_wdata[23:16] == ((bus_addr[1:0] == 2'd1) ? bus_wdata[31:24] : 8'h00)
      && bus_wdata[7:0] == ((bus_addr[1:0] == 2'd3) ? bus_wdata[31:24] : 8'h00));

  // R5
  word_repl_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_size == SZ_WORD |->
      bus_wdata[15:0] == (bus_addr[1] ? bus_wdata[31:16] : 16'h0000));

  // R3
  legal_offset_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_size == SZ_BYTE) || (bus_size == SZ_WORD && !bus_addr[0])
      || (bus_addr[1:0] == 2'b00));
endmodule

// File: tb/tb_bus_lane_steer.sv
`timescale 1ns/1ps
module tb_bus_lane_steer;
  localparam int AW = 32;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_write;
  logic [LW-1:0] req_wdata;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          bus_write;
  logic [31:0]   bus_wdata;
  logic          bus_ready;
  logic [31:0]   bus_rdata;
  logic [LW-1:0] rd_data;
  logic          done;
  logic          err;

  int checks = 0;
  int failures = 0;
  logic [LW-1:0] exp_rd = '0;

  always #4 clk = ~clk;

  bus_lane_steer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .rd_data(rd_data), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] f_wr(input logic [1:0] sz, input logic [1:0] off,
                                       input logic [31:0] op);
    logic [7:0]  b = op[7:0];
    logic [15:0] w = op[15:0];
    case ({sz, off})
      4'b0100: return {b, 24'h0};
      4'b0101: return {b, b, 16'h0};
      4'b0110: return {b, 8'h0, b, 8'h0};
      4'b0111: return {b, 16'h0, b};
      4'b1000: return {w, 16'h0};
      4'b1010: return {w, w};
      default: return op;
    endcase
  endfunction

  function automatic logic [31:0] f_rd(input logic [1:0] sz, input logic [1:0] off,
                                       input logic [31:0] d);
    case ({sz, off})
      4'b0100: return {24'h0, d[31:24]};
      4'b0101: return {24'h0, d[23:16]};
      4'b0110: return {24'h0, d[15:8]};
      4'b0111: return {24'h0, d[7:0]};
      4'b1000: return {16'h0, d[31:16]};
      4'b1010: return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic bit f_legal(input logic [1:0] sz, input logic [AW-1:0] a);
    case (sz)
      2'b01:   return 1'b1;
      2'b10:   return a[0] == 1'b0;
      2'b00:   return a[1:0] == 2'b00;
      default: return a[3:0] == 4'h0;
    endcase
  endfunction

  function automatic string f_wreq(input logic [1:0] sz);
    case (sz)
      2'b01: return "R4";
      2'b10: return "R5";
      2'b00: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic string f_rreq(input logic [1:0] sz);
    case (sz)
      2'b01: return "R7";
      2'b10: return "R8";
      2'b00: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic xfer(input logic [AW-1:0] a, input logic [1:0] sz, input bit wr,
                      input logic [LW-1:0] op, input int max_stall);
    int nbeats;
    logic [LW-1:0] gather;
    logic [31:0] rword;
    logic [31:0] exp_w;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = op;
    @(negedge clk);
    req_valid = 1'b0;
    if (!f_legal(sz, a)) begin
      chk(err == 1'b1, "R3 err pulse", LW'(err), 1);
      chk(bus_valid == 1'b0, "R3 no cycle", LW'(bus_valid), 0);
      @(negedge clk);
      chk(err == 1'b0 && bus_valid == 1'b0, "R3 one cycle", LW'({err, bus_valid}), 0);
      chk(rd_data == exp_rd, "R3 rd_data kept", rd_data, exp_rd);
      return;
    end
    // R2 address phase
    chk(bus_valid && bus_addr == a && bus_size == sz && bus_write == wr,
        "R2 address phase", LW'({bus_valid, bus_addr, bus_size, bus_write}),
        LW'({1'b1, a, sz, wr}));
    chk(err == 1'b0, "R3 no err on legal", LW'(err), 0);
    nbeats = (sz == 2'b11) ? 4 : 1;
    gather = '0;
    for (int k = 0; k < nbeats; k++) begin
      int stalls;
      exp_w = (sz == 2'b11) ? op[127-32*k -: 32] : f_wr(sz, a[1:0], op[31:0]);
      if (wr) chk(bus_wdata == exp_w, f_wreq(sz), LW'(bus_wdata), LW'(exp_w));
      chk(bus_addr == a + AW'(4*k), "R10 beat address", LW'(bus_addr), LW'(a + AW'(4*k)));
      stalls = (max_stall > 0) ? int'($urandom % (max_stall + 1)) : 0;
      for (int s = 0; s < stalls; s++) begin
        bus_ready = 1'b0;
        bus_rdata = $urandom;
        req_valid = 1'b1; req_addr = ~a; req_size = 2'b01; req_write = ~wr;
        req_wdata = ~op;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_valid && bus_addr == a + AW'(4*k) && bus_size == sz && bus_write == wr,
            "R11 hold while stalled", LW'(bus_addr), LW'(a + AW'(4*k)));
        chk(bus_valid && err == 1'b0 && done == 1'b0, "R13 busy request ignored",
            LW'({bus_valid, err, done}), LW'(3'b100));
        if (wr) chk(bus_wdata == exp_w, "R11 wdata hold", LW'(bus_wdata), LW'(exp_w));
      end
      bus_ready = 1'b1;
      rword = $urandom;
      bus_rdata = rword;
      gather = {gather[95:0], rword};
      @(negedge clk);
      bus_ready = 1'b0;
      bus_rdata = $urandom;
      if (k == nbeats - 1) begin
        chk(done == 1'b1 && bus_valid == 1'b0, "R12 done after last beat",
            LW'({done, bus_valid}), LW'(2'b10));
        if (!wr) exp_rd = (sz == 2'b11) ? gather : LW'(f_rd(sz, a[1:0], rword));
        chk(rd_data == exp_rd, wr ? "R12 rd_data kept on write" : f_rreq(sz),
            rd_data, exp_rd);
      end else begin
        chk(done == 1'b0 && bus_valid == 1'b1, "R10 mid-line beat",
            LW'({done, bus_valid}), LW'(2'b01));
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R12 single-cycle done", LW'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = 2'b00; req_write = 1'b0;
    req_wdata = '0; bus_ready = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(bus_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset outputs",
        LW'({bus_valid, done, err}), 0);
    chk(rd_data == '0, "R1 reset rd_data", rd_data, 0);

    // directed corners
    for (int o = 0; o < 4; o++) begin
      xfer(32'h1000_0000 + o, 2'b01, 1'b1, 128'hA5, 0);
      xfer(32'h1000_0000 + o, 2'b01, 1'b0, '0, 1);
    end
    xfer(32'h2000_0000, 2'b10, 1'b1, 128'hBEEF, 0);
    xfer(32'h2000_0002, 2'b10, 1'b1, 128'hC0DE, 0);
    xfer(32'h2000_0000, 2'b10, 1'b0, '0, 0);
    xfer(32'h2000_0002, 2'b10, 1'b0, '0, 2);
    xfer(32'h3000_0004, 2'b00, 1'b1, 128'h0123_4567, 1);
    xfer(32'h3000_0008, 2'b00, 1'b0, '0, 0);
    xfer(32'h4000_0010, 2'b11, 1'b1, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 2);
    xfer(32'h4000_0020, 2'b11, 1'b0, '0, 0);
    xfer(32'h4000_0030, 2'b11, 1'b0, '0, 2);
    xfer(32'h5000_0001, 2'b10, 1'b1, 128'h1, 0);
    xfer(32'h5000_0003, 2'b10, 1'b0, '0, 0);
    xfer(32'h5000_0002, 2'b00, 1'b0, '0, 0);
    xfer(32'h5000_0004, 2'b11, 1'b1, '1, 0);
    xfer(32'h5000_0008, 2'b11, 1'b0, '0, 0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [1:0]    sz;
      logic [LW-1:0] op;
      a  = $urandom;
      sz = 2'($urandom);
      op = {$urandom, $urandom, $urandom, $urandom};
      if (($urandom % 8) != 0) begin
        case (sz)
          2'b10:   a[0] = 1'b0;
          2'b00:   a[1:0] = 2'b00;
          2'b11:   a[3:0] = 4'h0;
          default: ;
        endcase
      end
      xfer(a, sz, 1'($urandom), op, 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule